// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

A synchronous memory of 16 Kb of data plus 2 Kb of parity, reached through two fully independent ports, A and B. Each port has its own clock, enable, write enable, address, write data and read data. The ports share nothing but the stored contents. A parameter sets each port's width to 1, 2, 4, 9, 18 or 36 bits, which gives the shapes 16K×1, 8K×2, 4K×4, 2K×9, 1K×18 and 512×36. The two ports may use different widths over the same contents.

For each port, one parameter chooses how the read output behaves during a write: it can show the old contents, show the new data, or stay unchanged. A second parameter adds one more register stage on that port's read output.

The memory is organised as 512 rows of 36 bits. Bits 31:0 of a row hold data and bits 35:32 hold parity. A port of data width D (8, 16 or 32 for the parity widths) sees 32/D slots in each row. Slot s holds data bits s·D and up, and parity bits from 32+s·P upward, where P is the number of parity bits per word.

Top module: `dpram_mw`

## Requirements
- R1: Each port samples its enable, write enable, address and write data on its own rising clock edge. Without the extra stage, the result of an enabled access is on the read output after that same edge. The two ports may access different locations in the same cycle, and neither access disturbs the other.
- R2: When a port's output stage is enabled, its read output shows the same value exactly one clock later than it would without the stage.
- R3: While a port's enable is low, the port ignores its address, write enable and write data, writes nothing, and its read output keeps its value.
- R4: A port in write-first mode (mode code 1) shows its own write data on the read output after a write.
- R5: A port in read-first mode (mode code 0) shows the contents the written location held before the write.
- R6: A port in no-change mode (mode code 2) leaves its read output unchanged across a write, while the write still updates the memory.
- R7: Let R be the ratio of the wider data width to the narrower one. Word N of the wider port covers addresses N·R through N·R+R−1 of the narrower port, and the lowest of those addresses sits in the least significant bits. In a 9-, 18- or 36-bit word the parity bits are the top bits: bit 8 of a 9-bit word, bits 17:16 of an 18-bit word, and bits 35:32 of a 36-bit word.
- R8: Parity bits live in a region of their own. A write from a 1-, 2- or 4-bit port leaves every parity bit unchanged.
- R9: Reset (active low, asynchronous) clears both read outputs, including the extra stages, to zero. The memory contents start at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous reset for the output registers |
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | AW_A (9 at default) | Port A word address |
| wdata_a | input | A_WIDTH | Port A write data (parity in the top bits) |
| rdata_a | output | A_WIDTH | Port A read data |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | AW_B (11 at default) | Port B word address |
| wdata_b | input | B_WIDTH | Port B write data (parity in the top bits) |
| rdata_b | output | B_WIDTH | Port B read data |

## Verification
The bench drives two instances. One pairs a 36-bit read-first port with a 9-bit write-first port that has the extra stage. The other pairs a 4-bit no-change port with an 18-bit read-first port that has the extra stage. Every read and write is checked cycle by cycle against a bit-level model of the rows.

Several corner cases get targeted checks:
- A design that routed slots in the wrong order or put parity in the data bits would return scrambled bytes when a narrow port reads words written by the wide port.
- A design whose narrow port wrote through into parity would lose the 18-bit parity bits after nibble writes.
- A misplaced output stage shows up as data one cycle early or late.
- A design that wrongly changes its output during a no-change write, or during idle cycles with junk on the inputs, is caught by hold checks on every cycle.

// File: rtl/dpram_mw_pkg.sv
package dpram_mw_pkg;

  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  localparam int ROW_COUNT     = 512;
  localparam int ROW_DATA_BITS = 32;
  localparam int ROW_PAR_BITS  = 4;
  localparam int ROW_BITS      = ROW_DATA_BITS + ROW_PAR_BITS;
  localparam int ROW_IDX_BITS  = $clog2(ROW_COUNT);

  // data part of a port word; the remaining top bits are parity
  function automatic int data_bits(input int w);
    int r;
    case (w)
      9:       r = 8;
      18:      r = 16;
      36:      r = 32;
      default: r = w;
    endcase
    return r;
  endfunction

  function automatic int addr_bits(input int w);
    return $clog2(ROW_COUNT * ROW_DATA_BITS / data_bits(w));
  endfunction

endpackage

// File: rtl/dpram_mw_outstage.sv
module dpram_mw_outstage
  import dpram_mw_pkg::*;
#(
  parameter int WIDTH   = 36,
  parameter bit OUT_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (OUT_REG) begin : g_reg
      logic [WIDTH-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
      end
      assign q = q_r;

      // R2: the extra stage delays the read value by exactly one clock
      a_r2_pipe_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(d)));
    end else begin : g_bypass
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/dpram_mw_port.sv
module dpram_mw_port
  import dpram_mw_pkg::*;
#(
  parameter int     WIDTH   = 36,
  parameter wmode_e WMODE   = WM_READ_FIRST,
  parameter bit     OUT_REG = 1'b0,
  localparam int    AW      = addr_bits(WIDTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [WIDTH-1:0]        wdata,
  output logic [WIDTH-1:0]        rdata,
  output logic [ROW_IDX_BITS-1:0] row_idx,
  input  logic [ROW_BITS-1:0]     peer_bits,
  input  logic [ROW_IDX_BITS-1:0] look_idx,
  output logic [ROW_BITS-1:0]     look_bits
);

  localparam int DW    = data_bits(WIDTH);
  localparam int PW    = WIDTH - DW;
  localparam int RATIO = ROW_DATA_BITS / DW;

  // this port's share of the contents; stored value = own bank ^ peer bank
  logic [ROW_BITS-1:0] bank [ROW_COUNT];

  logic [5:0]          slot;
  logic [5:0]          pos;
  logic [ROW_BITS-1:0] cur_row;
  logic [ROW_BITS-1:0] wmask;
  logic [ROW_BITS-1:0] wbits;
  logic [WIDTH-1:0]    old_word;
  logic [WIDTH-1:0]    rd_d;
  logic [WIDTH-1:0]    rd_q;

  initial begin
    for (int r = 0; r < ROW_COUNT; r++) bank[r] = '0;
  end

  // address split into row and slot within the row
  always_comb begin
    row_idx = ROW_IDX_BITS'(addr / AW'(RATIO));
    slot    = 6'(addr % AW'(RATIO));
  end

  // per-bit placement: data bits low in the row, parity bits in the top region
  always_comb begin
    cur_row  = bank[row_idx] ^ peer_bits;
    wmask    = '0;
    wbits    = '0;
    old_word = '0;
    pos      = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i < DW) pos = 6'(int'(slot) * DW + i);
      else        pos = 6'(ROW_DATA_BITS + int'(slot) * PW + i - DW);
      old_word[i] = cur_row[pos];
      wmask[pos]  = 1'b1;
      wbits[pos]  = wdata[i];
    end
  end

  assign look_bits = bank[look_idx];

  always_ff @(posedge clk) begin
    if (en && we) begin
      bank[row_idx] <= (bank[row_idx] & ~wmask) | ((wbits ^ peer_bits) & wmask);
    end
  end

  // read latch next state
  always_comb begin
    rd_d = rd_q;
    if (en) begin
      if (!we) begin
        rd_d = old_word;
      end else begin
        case (WMODE)
          WM_READ_FIRST:  rd_d = old_word;
          WM_WRITE_FIRST: rd_d = wdata;
          default:        rd_d = rd_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  dpram_mw_outstage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rd_q),
    .q     (rdata)
  );

  // R3: an idle port keeps its read value
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rd_q));

  generate
    if (WMODE == WM_WRITE_FIRST) begin : g_wf
      // R4: write data appears on the read latch
      a_r4_wf_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (rd_q == $past(wdata)));
    end else if (WMODE == WM_READ_FIRST) begin : g_rf
      // R5: previous contents appear on the read latch
      a_r5_rf_old: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (rd_q == $past(old_word)));
    end else begin : g_nc
      // R6: a write leaves the read latch untouched
      a_r6_nc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> $stable(rd_q));
    end
  endgenerate

endmodule

// File: rtl/dpram_mw.sv
module dpram_mw
  import dpram_mw_pkg::*;
#(
  parameter int     A_WIDTH   = 36,
  parameter int     B_WIDTH   = 9,
  parameter wmode_e A_MODE    = WM_READ_FIRST,
  parameter wmode_e B_MODE    = WM_WRITE_FIRST,
  parameter bit     A_OUT_REG = 1'b0,
  parameter bit     B_OUT_REG = 1'b1,
  localparam int    AW_A      = addr_bits(A_WIDTH),
  localparam int    AW_B      = addr_bits(B_WIDTH)
) (
  input  logic               rst_n,
  input  logic               clk_a,
  input  logic               en_a,
  input  logic               we_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [A_WIDTH-1:0] wdata_a,
  output logic [A_WIDTH-1:0] rdata_a,
  input  logic               clk_b,
  input  logic               en_b,
  input  logic               we_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [B_WIDTH-1:0] wdata_b,
  output logic [B_WIDTH-1:0] rdata_b
);

  logic [ROW_IDX_BITS-1:0] row_a;
  logic [ROW_IDX_BITS-1:0] row_b;
  logic [ROW_BITS-1:0]     bits_b_at_a;
  logic [ROW_BITS-1:0]     bits_a_at_b;

  dpram_mw_port #(.WIDTH(A_WIDTH), .WMODE(A_MODE), .OUT_REG(A_OUT_REG)) u_port_a (
    .clk       (clk_a),
    .rst_n     (rst_n),
    .en        (en_a),
    .we        (we_a),
    .addr      (addr_a),
    .wdata     (wdata_a),
    .rdata     (rdata_a),
    .row_idx   (row_a),
    .peer_bits (bits_b_at_a),
    .look_idx  (row_b),
    .look_bits (bits_a_at_b)
  );

  dpram_mw_port #(.WIDTH(B_WIDTH), .WMODE(B_MODE), .OUT_REG(B_OUT_REG)) u_port_b (
    .clk       (clk_b),
    .rst_n     (rst_n),
    .en        (en_b),
    .we        (we_b),
    .addr      (addr_b),
    .wdata     (wdata_b),
    .rdata     (rdata_b),
    .row_idx   (row_b),
    .peer_bits (bits_a_at_b),
    .look_idx  (row_a),
    .look_bits (bits_b_at_a)
  );

endmodule

// File: tb/dpram_mw_bench.sv
`timescale 1ns/1ps
module dpram_mw_bench;
  import dpram_mw_pkg::*;

  // port k: 0 = inst0 A, 1 = inst0 B, 2 = inst1 A, 3 = inst1 B
  localparam int PWID [4] = '{36, 9, 4, 18};
  localparam int PINST[4] = '{0, 0, 1, 1};
  localparam int PREG [4] = '{0, 1, 0, 1};
  localparam int PMODE[4] = '{0, 1, 2, 0};   // 0 read-first, 1 write-first, 2 no-change

  typedef struct {
    int           due;
    int           port;
    logic [35:0]  val;
    string        tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_s [4];
  logic        we_s [4];
  logic [13:0] ad_s [4];
  logic [35:0] di_s [4];
  logic [35:0] o0;
  logic [8:0]  o1;
  logic [3:0]  o2;
  logic [17:0] o3;

  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  exp_t        q[$];
  logic [35:0] mref [2][512];
  logic [35:0] st1 [4];
  logic        r_en [4];
  logic        r_we [4];
  int          r_ad [4];
  logic [35:0] r_di [4];
  string       r_tag [4];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpram_mw #(.A_WIDTH(36), .B_WIDTH(9), .A_MODE(WM_READ_FIRST), .B_MODE(WM_WRITE_FIRST),
             .A_OUT_REG(1'b0), .B_OUT_REG(1'b1)) u_dpram_mw (
    .rst_n(rst_n),
    .clk_a(clk), .en_a(en_s[0]), .we_a(we_s[0]), .addr_a(ad_s[0][8:0]),
    .wdata_a(di_s[0][35:0]), .rdata_a(o0),
    .clk_b(clk), .en_b(en_s[1]), .we_b(we_s[1]), .addr_b(ad_s[1][10:0]),
    .wdata_b(di_s[1][8:0]), .rdata_b(o1)
  );

  dpram_mw #(.A_WIDTH(4), .B_WIDTH(18), .A_MODE(WM_NO_CHANGE), .B_MODE(WM_READ_FIRST),
             .A_OUT_REG(1'b0), .B_OUT_REG(1'b1)) u_dpram_mw_second (
    .rst_n(rst_n),
    .clk_a(clk), .en_a(en_s[2]), .we_a(we_s[2]), .addr_a(ad_s[2][11:0]),
    .wdata_a(di_s[2][3:0]), .rdata_a(o2),
    .clk_b(clk), .en_b(en_s[3]), .we_b(we_s[3]), .addr_b(ad_s[3][9:0]),
    .wdata_b(di_s[3][17:0]), .rdata_b(o3)
  );

  function automatic logic [35:0] get_out(input int k);
    case (k)
      0:       return o0;
      1:       return 36'(o1);
      2:       return 36'(o2);
      default: return 36'(o3);
    endcase
  endfunction

  function automatic int dbits(input int w);
    return (w == 9) ? 8 : (w == 18) ? 16 : (w == 36) ? 32 : w;
  endfunction

  function automatic logic [35:0] wmask(input int k);
    return (36'(1) << PWID[k]) - 36'(1);
  endfunction

  function automatic int bitpos(input int k, input int a, input int i);
    int dw, pw, slot;
    dw = dbits(PWID[k]);
    pw = PWID[k] - dw;
    slot = a % (32 / dw);
    return (i < dw) ? slot * dw + i : 32 + slot * pw + i - dw;
  endfunction

  function automatic logic [35:0] ref_read(input int k, input int a);
    logic [35:0] r, row;
    r = '0;
    row = mref[PINST[k]][a / (32 / dbits(PWID[k]))];
    for (int i = 0; i < PWID[k]; i++) r[i] = row[bitpos(k, a, i)];
    return r;
  endfunction

  task automatic ref_write(input int k, input int a, input logic [35:0] d);
    int row;
    row = a / (32 / dbits(PWID[k]));
    for (int i = 0; i < PWID[k]; i++) mref[PINST[k]][row][bitpos(k, a, i)] = d[i];
  endtask

  task automatic op(input int k, input bit we, input int a, input logic [35:0] d, input string tag);
    r_en[k] = 1'b1; r_we[k] = we; r_ad[k] = a; r_di[k] = d & wmask(k); r_tag[k] = tag;
  endtask

  task automatic junk(input int k, input int a, input logic [35:0] d);
    r_en[k] = 1'b0; r_we[k] = 1'b1; r_ad[k] = a; r_di[k] = d; r_tag[k] = "R3";
  endtask

  // one clock: reads before writes, then pushes expected outputs per port
  task automatic tick();
    logic [35:0] old [4];
    exp_t e;
    @(negedge clk);
    for (int k = 0; k < 4; k++) old[k] = r_en[k] ? ref_read(k, r_ad[k]) : '0;
    for (int k = 0; k < 4; k++) begin
      if (r_en[k]) begin
        if (!r_we[k] || PMODE[k] == 0) st1[k] = old[k];
        else if (PMODE[k] == 1)        st1[k] = r_di[k];
        if (r_we[k]) ref_write(k, r_ad[k], r_di[k]);
      end
      e.due = cyc + 1 + PREG[k]; e.port = k; e.val = st1[k]; e.tag = r_tag[k];
      q.push_back(e);
      en_s[k] = r_en[k]; we_s[k] = r_we[k]; ad_s[k] = 14'(r_ad[k]); di_s[k] = r_di[k];
      r_en[k] = 1'b0; r_we[k] = 1'b0; r_ad[k] = 0; r_di[k] = '0; r_tag[k] = "R3";
    end
  endtask

  task automatic check(input string tag, input int k, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s port%0d cyc=%0d actual=%h expected=%h", tag, k, cyc, act, exp);
    end
  endtask

  // monitor: compare every expected item on its due cycle
  initial begin
    forever begin
      @(negedge clk);
      for (int i = 0; i < q.size(); ) begin
        if (q[i].due == cyc) begin
          check(q[i].tag, q[i].port, get_out(q[i].port), q[i].val);
          q.delete(i);
        end else begin
          i++;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    int row;
    for (int k = 0; k < 4; k++) begin
      en_s[k] = 1'b0; we_s[k] = 1'b0; ad_s[k] = '0; di_s[k] = '0; st1[k] = '0;
      r_en[k] = 1'b0; r_we[k] = 1'b0; r_ad[k] = 0; r_di[k] = '0; r_tag[k] = "R3";
    end
    for (int n = 0; n < 2; n++) for (int r = 0; r < 512; r++) mref[n][r] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) check("R9", k, get_out(k), 36'h0);

    // R9: unwritten locations read zero
    op(0, 0, 5, 0, "R9"); op(1, 0, 100, 0, "R9"); tick();
    // R5: read-first writes show old contents
    op(0, 1, 0, 36'hA_1234_5678, "R5"); tick();
    op(0, 1, 0, 36'h5_DEAD_BEEF, "R5"); tick();
    op(0, 1, 1, 36'h3_CAFE_F00D, "R5"); tick();
    op(0, 1, 2, 36'h0_0102_0304, "R5"); tick();
    // R7: 9-bit view of the 36-bit words, through the extra stage (R2)
    for (int a = 0; a < 8; a++) begin op(1, 0, a, 0, (a < 4) ? "R7" : "R2"); tick(); end
    // R4: write-first on the 9-bit port, then the wide view (R7)
    op(1, 1, 9, 36'h1AB, "R4"); tick();
    op(1, 1, 11, 36'h055, "R4"); tick();
    op(0, 0, 2, 0, "R7"); tick();
    // R1: both ports in the same cycle on different rows
    op(0, 1, 3, 36'hF_0F0F_1234, "R1"); op(1, 0, 4, 0, "R1"); tick();
    op(0, 0, 3, 0, "R1"); op(1, 1, 1, 36'h0C3, "R1"); tick();
    // R3: idle cycles with junk on the inputs, then read back
    for (int j = 0; j < 4; j++) begin
      junk(0, j, 36'hF_FFFF_FFFF); junk(1, 3 + j, 36'h1FF); junk(2, j, 36'hF); junk(3, j, 36'h3FFFF);
      tick();
    end
    op(0, 0, 0, 0, "R3"); op(1, 0, 0, 0, "R3"); tick();
    op(0, 0, 1, 0, "R3"); op(3, 0, 0, 0, "R3"); tick();
    // R6 / R8 on the second instance
    op(3, 1, 0, 36'h3_1234, "R5"); tick();
    op(3, 1, 1, 36'h0_ABCD, "R5"); tick();
    op(2, 0, 4, 0, "R7"); tick();
    op(2, 1, 0, 36'hF, "R6"); tick();
    op(2, 1, 1, 36'hE, "R6"); tick();
    op(2, 1, 5, 36'h9, "R6"); tick();
    op(3, 0, 0, 0, "R8"); tick();
    op(3, 0, 1, 0, "R8"); tick();
    op(3, 1, 40, 36'h3_0000, "R8"); tick();
    for (int a = 160; a < 164; a++) begin op(2, 1, a, 36'(a & 15), "R8"); tick(); end
    op(3, 0, 40, 0, "R8"); op(2, 0, 161, 0, "R2"); tick();
    // R1: mixed random traffic on disjoint rows per port
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 240; n++) begin
      for (int k = 0; k < 4; k++) begin
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
        if (lf[0]) begin
          row = (k == 0 || k == 2) ? 32 + 2 * int'(lf[6:3]) : 65 + 2 * int'(lf[6:3]);
          case (k)
            0:       op(k, lf[1], row, {lf[31:28], lf[31:0]}, "R1");
            1:       op(k, lf[1], row * 4 + int'(lf[9:8]), 36'(lf[31:20]), "R1");
            2:       op(k, lf[1], row * 8 + int'(lf[10:8]), 36'(lf[31:20]), "R1");
            default: op(k, lf[1], row * 2 + int'(lf[8]), 36'(lf[31:12]), "R1");
          endcase
        end
      end
      tick();
    end
    repeat (4) tick();
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1 pending actual=%0d expected=0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule